// File: doc/BRIEF.md
# Quad Multiply Add-Subtract Summation Element

This block multiplies four operand pairs and reduces the four products to one result. Lanes 0 and 1 form the first partial result, P0 ± P1. Lanes 2 and 3 form the second, P2 ± P3. The two partial results are then added. Operand A is `AW` bits wide and operand B is `BW` bits wide. Each product is `AW+BW` bits, each partial result is one bit wider, and the final sum is two bits wider than a product. Two control inputs decide, separately for A and for B, whether the operands are two's complement or unsigned. Two further inputs pick add or subtract, one for each pair.

There are three register groups: the input group, the pipeline group behind the multipliers, and the output group. Parameters enable or bypass each group. The pipeline group is enabled by default, and so are the other two in the default build. Each group takes its clock, clock enable and reset from one of four shared sources, chosen by parameter index. The input registers of each operand also form a four-deep shift chain, with a serial input and a serial output.

The data path has no valid/ready handshake. Back-pressure is applied by lowering a group's clock enable, which freezes that group while the other groups keep running. Results emerge at a fixed latency once the enables are high.

Top module: `qmas_top`

## Requirements
- R1: `sum_o` equals (A0·B0 ± A1·B1) + (A2·B2 ± A3·B3), computed exactly and taken modulo 2^(AW+BW+2).
- R2: `add0_i` controls the first pair and `add1_i` controls the second. A value of 1 adds and a value of 0 subtracts the odd-lane product. The two pairs are controlled independently.
- R3: `a_sgn_i` = 1 makes every A operand two's complement, and 0 makes it unsigned. `b_sgn_i` does the same for the B operands.
- R4: Latency is IN_REG + PIPE_REG + OUT_REG cycles. The sign and add/subtract controls are registered in the input group together with their operands.
- R5: When `shift_a_i` = 1 and the input group is enabled, A register 0 loads `a_sri_i` and A register k loads A register k-1. `a_sro_o` always shows A register 3. The B chain behaves the same way under `shift_b_i`, `b_sri_i` and `b_sro_o`.
- R6: When the shift control is 0, each input register loads its parallel lane input. `a_sro_o` then shows the lane-3 operand one cycle later.
- R7: A low clock enable on a group's selected source holds every register in that group. The other groups keep running.
- R8: A high reset on a group's selected source clears that group's registers to zero on the next edge of its clock. Reset takes effect even when the group's enable is low.
- R9: Each group responds only to its selected clock, enable and reset indices. Activity on unselected indices has no effect on any output.
- R10: After all groups are reset, `sum_o`, `a_sro_o` and `b_sro_o` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 4 | Clock sources |
| ce_i | input | 4 | Clock-enable sources |
| rst_i | input | 4 | Synchronous reset sources, active high |
| a_i | input | 4×AW | A operands, lane k in slice k |
| b_i | input | 4×BW | B operands, lane k in slice k |
| a_sgn_i | input | 1 | A operands are two's complement when 1 |
| b_sgn_i | input | 1 | B operands are two's complement when 1 |
| add0_i | input | 1 | First pair: 1 adds, 0 subtracts |
| add1_i | input | 1 | Second pair: 1 adds, 0 subtracts |
| shift_a_i | input | 1 | A input registers shift instead of loading |
| shift_b_i | input | 1 | B input registers shift instead of loading |
| a_sri_i | input | AW | Serial input of the A chain |
| b_sri_i | input | BW | Serial input of the B chain |
| a_sro_o | output | AW | Serial output of the A chain (register 3) |
| b_sro_o | output | BW | Serial output of the B chain (register 3) |
| sum_o | output | AW+BW+2 | Final sum |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a group's reset arrives while its clock enable is low. The bench provokes this by raising the output-group reset with that group frozen, and again for the input group. It judges the result by `sum_o`, or by the serial outputs, reading zero one cycle later. In the second, a shift into the input chain happens while a downstream group is frozen. The bench judges this with a cycle-accurate model of the three groups: the model predicts both the held result and the serial-output values.

// File: rtl/qmas_pkg.sv
package qmas_pkg;

  localparam int NLANE = 4;
  localparam int NSRC  = 4;

  typedef enum logic {
    OP_SUB = 1'b0,
    OP_ADD = 1'b1
  } qmas_op_e;

  typedef struct packed {
    logic a_sgn;
    logic b_sgn;
    logic add0;
    logic add1;
  } qmas_ctl_t;

endpackage

// File: rtl/qmas_optreg.sv
module qmas_optreg #(
  parameter int W  = 1,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         ce,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ce) q <= d;
      end
    end else begin : g_bypass
      logic unused_ctl;
      assign unused_ctl = clk ^ ce ^ rst;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/qmas_inchain.sv
module qmas_inchain #(
  parameter int W  = 9,
  parameter bit EN = 1'b1,
  parameter int N  = 4
) (
  input  logic                clk,
  input  logic                ce,
  input  logic                rst,
  input  logic                shift,
  input  logic [W-1:0]        sri,
  input  logic [N-1:0][W-1:0] din,
  output logic [N-1:0][W-1:0] dout,
  output logic [W-1:0]        sro
);

  logic [W-1:0] stg [N+1];

  assign stg[0] = sri;
  assign sro    = stg[N];

  generate
    for (genvar k = 0; k < N; k++) begin : g_lane
      logic [W-1:0] nxt;
      assign nxt = shift ? stg[k] : din[k];
      if (EN) begin : g_reg
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
          if (rst)     q <= '0;
          else if (ce) q <= nxt;
        end
        assign stg[k+1] = q;
      end else begin : g_bypass
        assign stg[k+1] = nxt;
      end
      assign dout[k] = stg[k+1];
    end
    if (!EN) begin : g_unused
      logic unused_ctl;
      assign unused_ctl = clk ^ ce ^ rst;
    end
  endgenerate

endmodule

// File: rtl/qmas_mult.sv
module qmas_mult #(
  parameter int AW = 9,
  parameter int BW = 9
) (
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  input  logic             a_sgn,
  input  logic             b_sgn,
  output logic [AW+BW-1:0] p
);

  localparam int PW = AW + BW;

  logic signed [PW-1:0] ax;
  logic signed [PW-1:0] bx;

  // extend both operands to product width, then keep the low bits
  assign ax = {{BW{a_sgn & a[AW-1]}}, a};
  assign bx = {{AW{b_sgn & b[BW-1]}}, b};
  assign p  = ax * bx;

endmodule

// File: rtl/qmas_sum.sv
module qmas_sum
  import qmas_pkg::*;
#(
  parameter int PW = 18
) (
  input  logic [NLANE-1:0][PW-1:0] p,
  input  logic                     p_sgn,
  input  logic                     add0,
  input  logic                     add1,
  output logic [PW+1:0]            s
);

  logic [PW:0] e0, e1, e2, e3;
  logic [PW:0] s0, s1;
  logic        f0, f1;

  always_comb begin
    e0 = {p_sgn & p[0][PW-1], p[0]};
    e1 = {p_sgn & p[1][PW-1], p[1]};
    e2 = {p_sgn & p[2][PW-1], p[2]};
    e3 = {p_sgn & p[3][PW-1], p[3]};
    s0 = (qmas_op_e'(add0) == OP_ADD) ? e0 + e1 : e0 - e1;
    s1 = (qmas_op_e'(add1) == OP_ADD) ? e2 + e3 : e2 - e3;
    // a partial result is signed unless it is an unsigned addition
    f0 = p_sgn | ~add0;
    f1 = p_sgn | ~add1;
    s  = {f0 & s0[PW], s0} + {f1 & s1[PW], s1};
  end

endmodule

// File: rtl/qmas_top.sv
module qmas_top
  import qmas_pkg::*;
#(
  parameter int AW       = 9,
  parameter int BW       = 9,
  parameter bit IN_REG   = 1'b1,
  parameter bit PIPE_REG = 1'b1,
  parameter bit OUT_REG  = 1'b1,
  parameter int IN_CLK   = 0,
  parameter int IN_CE    = 0,
  parameter int IN_RST   = 0,
  parameter int PIPE_CLK = 1,
  parameter int PIPE_CE  = 1,
  parameter int PIPE_RST = 1,
  parameter int OUT_CLK  = 2,
  parameter int OUT_CE   = 2,
  parameter int OUT_RST  = 2
) (
  input  logic [NSRC-1:0]           clk_i,
  input  logic [NSRC-1:0]           ce_i,
  input  logic [NSRC-1:0]           rst_i,
  input  logic [NLANE-1:0][AW-1:0]  a_i,
  input  logic [NLANE-1:0][BW-1:0]  b_i,
  input  logic                      a_sgn_i,
  input  logic                      b_sgn_i,
  input  logic                      add0_i,
  input  logic                      add1_i,
  input  logic                      shift_a_i,
  input  logic                      shift_b_i,
  input  logic [AW-1:0]             a_sri_i,
  input  logic [BW-1:0]             b_sri_i,
  output logic [AW-1:0]             a_sro_o,
  output logic [BW-1:0]             b_sro_o,
  output logic [AW+BW+1:0]          sum_o
);

  localparam int PW     = AW + BW;
  localparam int SW     = PW + 2;
  localparam int CTL_W  = $bits(qmas_ctl_t);
  localparam int PIPE_W = NLANE * PW + 3;

  // register-group source selection
  logic in_clk, in_ce, in_rst;
  logic pp_clk, pp_ce, pp_rst;
  logic out_clk, out_ce, out_rst;
  logic unused_src;

  assign in_clk  = clk_i[IN_CLK];
  assign in_ce   = ce_i[IN_CE];
  assign in_rst  = rst_i[IN_RST];
  assign pp_clk  = clk_i[PIPE_CLK];
  assign pp_ce   = ce_i[PIPE_CE];
  assign pp_rst  = rst_i[PIPE_RST];
  assign out_clk = clk_i[OUT_CLK];
  assign out_ce  = ce_i[OUT_CE];
  assign out_rst = rst_i[OUT_RST];
  assign unused_src = ^{clk_i, ce_i, rst_i};

  // input group: controls and the two operand chains
  qmas_ctl_t ctl_d, ctl_q;

  always_comb begin
    ctl_d.a_sgn = a_sgn_i;
    ctl_d.b_sgn = b_sgn_i;
    ctl_d.add0  = add0_i;
    ctl_d.add1  = add1_i;
  end

  qmas_optreg #(.W(CTL_W), .EN(IN_REG)) u_ctl_reg (
    .clk (in_clk),
    .ce  (in_ce),
    .rst (in_rst),
    .d   (ctl_d),
    .q   (ctl_q)
  );

  logic [NLANE-1:0][AW-1:0] a_op;
  logic [NLANE-1:0][BW-1:0] b_op;

  qmas_inchain #(.W(AW), .EN(IN_REG), .N(NLANE)) u_a_chain (
    .clk   (in_clk),
    .ce    (in_ce),
    .rst   (in_rst),
    .shift (shift_a_i),
    .sri   (a_sri_i),
    .din   (a_i),
    .dout  (a_op),
    .sro   (a_sro_o)
  );

  qmas_inchain #(.W(BW), .EN(IN_REG), .N(NLANE)) u_b_chain (
    .clk   (in_clk),
    .ce    (in_ce),
    .rst   (in_rst),
    .shift (shift_b_i),
    .sri   (b_sri_i),
    .din   (b_i),
    .dout  (b_op),
    .sro   (b_sro_o)
  );

  // multipliers
  logic [NLANE-1:0][PW-1:0] prod;

  generate
    for (genvar k = 0; k < NLANE; k++) begin : g_mul
      qmas_mult #(.AW(AW), .BW(BW)) u_mul (
        .a     (a_op[k]),
        .b     (b_op[k]),
        .a_sgn (ctl_q.a_sgn),
        .b_sgn (ctl_q.b_sgn),
        .p     (prod[k])
      );
    end
  endgenerate

  // pipeline group: products with their controls
  logic [PIPE_W-1:0]        pipe_d, pipe_q;
  logic [NLANE-1:0][PW-1:0] prod_q;
  logic                     psgn_q, add0_q, add1_q;

  assign pipe_d = {prod, ctl_q.a_sgn | ctl_q.b_sgn, ctl_q.add1, ctl_q.add0};

  qmas_optreg #(.W(PIPE_W), .EN(PIPE_REG)) u_pipe_reg (
    .clk (pp_clk),
    .ce  (pp_ce),
    .rst (pp_rst),
    .d   (pipe_d),
    .q   (pipe_q)
  );

  assign prod_q = pipe_q[PIPE_W-1:3];
  assign psgn_q = pipe_q[2];
  assign add1_q = pipe_q[1];
  assign add0_q = pipe_q[0];

  // add/subtract pairs and final summation
  logic [SW-1:0] sum_d;

  qmas_sum #(.PW(PW)) u_sum (
    .p     (prod_q),
    .p_sgn (psgn_q),
    .add0  (add0_q),
    .add1  (add1_q),
    .s     (sum_d)
  );

  // output group
  qmas_optreg #(.W(SW), .EN(OUT_REG)) u_out_reg (
    .clk (out_clk),
    .ce  (out_ce),
    .rst (out_rst),
    .d   (sum_d),
    .q   (sum_o)
  );

endmodule

// File: rtl/qmas_chk.sv
module qmas_chk #(
  parameter int AW      = 9,
  parameter int SW      = 20,
  parameter bit IN_REG  = 1'b1,
  parameter bit OUT_REG = 1'b1,
  parameter int IN_CLK  = 0,
  parameter int IN_CE   = 0,
  parameter int IN_RST  = 0,
  parameter int OUT_CLK = 2,
  parameter int OUT_CE  = 2,
  parameter int OUT_RST = 2
) (
  input logic [3:0]          clk_i,
  input logic [3:0]          ce_i,
  input logic [3:0]          rst_i,
  input logic                shift_a_i,
  input logic [AW-1:0]       a_sri_i,
  input logic [3:0][AW-1:0]  a_op,
  input logic [AW-1:0]       a_sro_o,
  input logic [SW-1:0]       sum_o
);

  logic unused_chk;
  assign unused_chk = ^{clk_i, ce_i, rst_i, shift_a_i, a_sri_i, a_op, a_sro_o, sum_o};

  generate
    if (IN_REG) begin : g_in
      logic ck;
      assign ck = clk_i[IN_CLK];

      p_chain_head_r5: assert property (@(posedge ck) disable iff (rst_i[IN_RST])
        (ce_i[IN_CE] && shift_a_i) |=> (a_op[0] == $past(a_sri_i)));

      p_chain_tail_r5: assert property (@(posedge ck) disable iff (rst_i[IN_RST])
        (ce_i[IN_CE] && shift_a_i) |=> (a_sro_o == $past(a_op[2])));

      p_in_hold_r7: assert property (@(posedge ck) disable iff (rst_i[IN_RST])
        !ce_i[IN_CE] |=> $stable(a_op));

      p_in_clear_r8: assert property (@(posedge ck)
        rst_i[IN_RST] |=> (a_op == '0));
    end
    if (OUT_REG) begin : g_out
      logic ck;
      assign ck = clk_i[OUT_CLK];

      p_out_hold_r7: assert property (@(posedge ck) disable iff (rst_i[OUT_RST])
        !ce_i[OUT_CE] |=> $stable(sum_o));

      p_out_clear_r8: assert property (@(posedge ck)
        rst_i[OUT_RST] |=> (sum_o == '0));
    end
  endgenerate

endmodule

bind qmas_top qmas_chk #(
  .AW      (AW),
  .SW      (AW + BW + 2),
  .IN_REG  (IN_REG),
  .OUT_REG (OUT_REG),
  .IN_CLK  (IN_CLK),
  .IN_CE   (IN_CE),
  .IN_RST  (IN_RST),
  .OUT_CLK (OUT_CLK),
  .OUT_CE  (OUT_CE),
  .OUT_RST (OUT_RST)
) u_qmas_chk (
  .clk_i     (clk_i),
  .ce_i      (ce_i),
  .rst_i     (rst_i),
  .shift_a_i (shift_a_i),
  .a_sri_i   (a_sri_i),
  .a_op      (a_op),
  .a_sro_o   (a_sro_o),
  .sum_o     (sum_o)
);

// File: tb/test_qmas_top.sv
module test_qmas_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 9;
  localparam int BW = 9;
  localparam int SW = AW + BW + 2;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [3:0]          clk_i;
  logic [3:0]          ce_i  = 4'b0000;
  logic [3:0]          rst_i = 4'b1111;
  logic [3:0][AW-1:0]  a_i   = '0;
  logic [3:0][BW-1:0]  b_i   = '0;
  logic a_sgn_i = 1'b0, b_sgn_i = 1'b0, add0_i = 1'b0, add1_i = 1'b0;
  logic shift_a_i = 1'b0, shift_b_i = 1'b0;
  logic [AW-1:0] a_sri_i = '0;
  logic [BW-1:0] b_sri_i = '0;
  logic [AW-1:0] a_sro_o;
  logic [BW-1:0] b_sro_o;
  logic [SW-1:0] sum_o;

  // index 3 carries no clock; groups use indices 0..2
  assign clk_i = {1'b0, clk, clk, clk};

  qmas_top i_qmas_top (
    .clk_i, .ce_i, .rst_i, .a_i, .b_i, .a_sgn_i, .b_sgn_i, .add0_i, .add1_i,
    .shift_a_i, .shift_b_i, .a_sri_i, .b_sri_i, .a_sro_o, .b_sro_o, .sum_o
  );

  int n_chk  = 0;
  int n_fail = 0;

  // stimulus for the next edge
  logic [AW-1:0] na [4];
  logic [BW-1:0] nb [4];
  logic nsa, nsb, nad0, nad1, nsha, nshb;
  logic [AW-1:0] nsra;
  logic [BW-1:0] nsrb;
  logic [3:0] nce, nrst;

  // model of the register groups
  logic [AW-1:0] ma [4];
  logic [BW-1:0] mb [4];
  logic msa, msb, mad0, mad1;
  logic [SW-1:0] m_pipe, m_out;

  function automatic logic [SW-1:0] ref_sum(input logic [AW-1:0] a [4],
      input logic [BW-1:0] b [4], input logic sa, input logic sb,
      input logic ad0, input logic ad1);
    longint pr [4];
    longint tot;
    for (int k = 0; k < 4; k++) begin
      longint av = longint'(a[k]);
      longint bv = longint'(b[k]);
      if (sa && a[k][AW-1]) av = av - (longint'(1) <<< AW);
      if (sb && b[k][BW-1]) bv = bv - (longint'(1) <<< BW);
      pr[k] = av * bv;
    end
    tot = (ad0 ? pr[0] + pr[1] : pr[0] - pr[1]) + (ad1 ? pr[2] + pr[3] : pr[2] - pr[3]);
    return SW'(tot);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(negedge clk);
    check(sum_o == m_out, tag, "sum_o", longint'(sum_o), longint'(m_out));
    check(a_sro_o == ma[3], tag, "a_sro_o", longint'(a_sro_o), longint'(ma[3]));
    check(b_sro_o == mb[3], tag, "b_sro_o", longint'(b_sro_o), longint'(mb[3]));
    for (int k = 0; k < 4; k++) begin
      a_i[k] = na[k];
      b_i[k] = nb[k];
    end
    a_sgn_i = nsa; b_sgn_i = nsb; add0_i = nad0; add1_i = nad1;
    shift_a_i = nsha; shift_b_i = nshb; a_sri_i = nsra; b_sri_i = nsrb;
    ce_i = nce; rst_i = nrst;
    // model of the coming edge, output first so it sees the old pipeline
    if (nrst[2]) m_out = '0; else if (nce[2]) m_out = m_pipe;
    if (nrst[1]) m_pipe = '0; else if (nce[1]) m_pipe = ref_sum(ma, mb, msa, msb, mad0, mad1);
    if (nrst[0]) begin
      for (int k = 0; k < 4; k++) begin ma[k] = '0; mb[k] = '0; end
      msa = 0; msb = 0; mad0 = 0; mad1 = 0;
    end else if (nce[0]) begin
      if (nsha) begin
        for (int k = 3; k > 0; k--) ma[k] = ma[k-1];
        ma[0] = nsra;
      end else for (int k = 0; k < 4; k++) ma[k] = na[k];
      if (nshb) begin
        for (int k = 3; k > 0; k--) mb[k] = mb[k-1];
        mb[0] = nsrb;
      end else for (int k = 0; k < 4; k++) mb[k] = nb[k];
      msa = nsa; msb = nsb; mad0 = nad0; mad1 = nad1;
    end
  endtask

  task automatic rnd_ops();
    for (int k = 0; k < 4; k++) begin
      na[k] = AW'($urandom);
      nb[k] = BW'($urandom);
    end
    nsa = 1'($urandom); nsb = 1'($urandom);
    nad0 = 1'($urandom); nad1 = 1'($urandom);
    nsra = AW'($urandom); nsrb = BW'($urandom);
  endtask

  // unselected index 3 toggles freely (R9)
  task automatic rnd_spare();
    nce[3]  = 1'($urandom);
    nrst[3] = 1'($urandom);
  endtask

  task automatic set_all(input logic [AW-1:0] av, input logic [BW-1:0] bv);
    for (int k = 0; k < 4; k++) begin na[k] = av; nb[k] = bv; end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) begin ma[k] = '0; mb[k] = '0; na[k] = '0; nb[k] = '0; end
    msa = 0; msb = 0; mad0 = 0; mad1 = 0; m_pipe = '0; m_out = '0;
    nsa = 0; nsb = 0; nad0 = 0; nad1 = 0; nsha = 0; nshb = 0; nsra = '0; nsrb = '0;

    // R10: state after reset of all groups
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(sum_o == '0, "R10", "sum_o", longint'(sum_o), 0);
    check(a_sro_o == '0, "R10", "a_sro_o", longint'(a_sro_o), 0);
    check(b_sro_o == '0, "R10", "b_sro_o", longint'(b_sro_o), 0);

    // R1 R3 R4 R6 R9: random operands, parallel load, latency 3
    nce = 4'b0111; nrst = 4'b0000;
    for (int i = 0; i < 300; i++) begin
      rnd_ops(); rnd_spare();
      tick("R1/R4/R6/R9");
    end

    // R2 R3: directed corners
    nce = 4'b0111; nrst = 4'b0000;
    set_all('1, '1); nsa = 0; nsb = 0; nad0 = 1; nad1 = 1; tick("R3 unsigned max add");
    set_all(AW'(1) << (AW-1), BW'(1) << (BW-1)); nsa = 1; nsb = 1; tick("R3 signed min");
    set_all('0, '0); na[1] = '1; nb[1] = '1; na[3] = '1; nb[3] = '1;
    nsa = 0; nsb = 0; nad0 = 0; nad1 = 0; tick("R2 unsigned subtract");
    nad0 = 1; nad1 = 0; tick("R2 mixed ops");
    set_all('1, '1); nsa = 1; nsb = 0; nad0 = 0; nad1 = 1; tick("R3 signed A unsigned B");
    nsa = 0; nsb = 1; tick("R3 unsigned A signed B");
    repeat (3) tick("R4 flush");

    // R5: shift both chains, then A alone
    nsha = 1; nshb = 1;
    for (int i = 0; i < 8; i++) begin rnd_ops(); tick("R5 shift both"); end
    nshb = 0;
    for (int i = 0; i < 6; i++) begin rnd_ops(); tick("R5 shift A"); end
    nsha = 0;
    repeat (4) begin rnd_ops(); tick("R6 reload"); end

    // R7: freeze each group in turn, with a shift during the freezes
    nce = 4'b0110;
    for (int i = 0; i < 5; i++) begin rnd_ops(); nsha = 1'(i & 1); rnd_spare(); tick("R7 input frozen"); end
    nsha = 0;
    nce = 4'b0101;
    for (int i = 0; i < 5; i++) begin rnd_ops(); rnd_spare(); tick("R7 pipeline frozen"); end
    nce = 4'b0011;
    for (int i = 0; i < 5; i++) begin rnd_ops(); nsha = 1; rnd_spare(); tick("R7 output frozen"); end
    nsha = 0;

    // R8: reset while enable is low
    nce = 4'b0011; nrst = 4'b0100; rnd_ops(); tick("R8 output reset, enable low");
    nrst = 4'b0000; tick("R8 output cleared");
    nce = 4'b0110; nrst = 4'b0001; rnd_ops(); tick("R8 input reset, enable low");
    nrst = 4'b0000; tick("R8 input cleared");
    nce = 4'b0111; nrst = 4'b0010; tick("R8 pipeline reset");
    nrst = 4'b0000;
    for (int i = 0; i < 100; i++) begin
      rnd_ops(); rnd_spare();
      nce[2:0] = ($urandom % 4 == 0) ? 3'(1 << ($urandom % 3)) ^ 3'b111 : 3'b111;
      nsha = 1'($urandom); nshb = 1'($urandom);
      tick("R1/R7/R9 mixed");
    end
    nce = 4'b0111; nsha = 0; nshb = 0;
    repeat (4) tick("R4 drain");

    summary();
    $finish;
  end

endmodule